// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block merges four reset requests (power-on, brown-out, external pin and watchdog) into one internal reset. It holds that reset until the internal RC oscillator reports a stable clock. The release of each reset request passes through its own two-flop synchronizer, so the reset asserts asynchronously and releases in step with the oscillator clock.

When the internal reset releases, two counters start on the same edge. A short CPU counter enables the processor to run. A longer memory counter starts a fixed-length memory initialisation phase, and a memory-access grant follows that phase. The processor can therefore start booting before memory is usable. Any memory access it issues in that gap is stalled by a wait-request output. The block also keeps a fetch pointer that starts at address 0 and advances by one word for each access that is accepted.

Once the grant is up, a power-down request clears the counters. A request from any wake-up source then starts the whole counter sequence again.

Top module: `rws_top`

## Requirements
- R1: While any one of `rst_ni` (low), `bor_rst_i`, `ext_rst_i` or `wdt_rst_i` is active, `sys_rst_o` is 1, and `cpu_run_o`, `mem_init_o`, `mem_grant_o` and `fetch_addr_o` are 0. This takes effect at once, without waiting for a clock edge.
- R2: `osc_stable_i` at 0 acts as a further reset request. `sys_rst_o` falls on the second rising clock edge after all reset requests are inactive and `osc_stable_i` is 1.
- R3: `cpu_run_o` rises CPU_TC rising edges after the edge on which `sys_rst_o` falls. With the default CPU_TC of 3, it stays low after 2 edges and is high after 3 edges.
- R4: `mem_init_o` rises MEM_TC edges after the release edge. The memory counter starts on the same edge as the CPU counter.
- R5: `mem_init_o` stays high for exactly INIT_LEN cycles. On the edge where it falls, `mem_grant_o` rises.
- R6: `mem_wait_o` is 1 exactly when `mem_req_i` is 1 and `mem_grant_o` is 0.
- R7: `fetch_addr_o` is 0 after any reset. It advances by 4 on each rising edge where `mem_req_i`, `cpu_run_o` and `mem_grant_o` are all 1, and holds its value otherwise.
- R8: When `pd_req_i` is 1 at an edge while `mem_grant_o` is 1, power-down starts, and the next edge clears `cpu_run_o`, `mem_init_o` and `mem_grant_o`. When `pd_req_i` is 1 before the grant, it has no effect.
- R9: During power-down, any bit of `wake_req_i` set at an edge ends power-down. `cpu_run_o` then rises CPU_TC edges later, and `mem_grant_o` rises MEM_TC+INIT_LEN edges later. `wake_req_i` has no effect outside power-down.
- R10: If a reset request arrives part-way through the sequence, all counters and the grant clear at once. The next release starts the sequence again from the beginning, with the R2 to R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RC oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low |
| bor_rst_i | input | 1 | Brown-out reset request, active high |
| ext_rst_i | input | 1 | External pin reset request, active high |
| wdt_rst_i | input | 1 | Watchdog reset request, active high |
| osc_stable_i | input | 1 | RC oscillator reports a stable clock |
| wake_req_i | input | NUM_WAKE | Wake-up requests, one bit per source |
| pd_req_i | input | 1 | Enter power-down |
| mem_req_i | input | 1 | CPU memory access request |
| sys_rst_o | output | 1 | Synchronized internal reset, active high |
| cpu_run_o | output | 1 | CPU may run |
| mem_init_o | output | 1 | Memory initialisation in progress |
| mem_grant_o | output | 1 | Memory access granted |
| mem_wait_o | output | 1 | Stall the current CPU memory access |
| fetch_addr_o | output | ADDR_W | CPU fetch pointer |

## Verification
The bench walks a full power-up with `mem_req_i` held high. This shows the CPU enable rising many cycles before the grant, with wait asserted throughout the gap and the fetch pointer frozen at 0. A power-down request given before the grant is checked to have no effect, while one given after the grant clears all outputs. Wake-up from the lowest and the highest source bits restarts the sequence with the same edge counts as a cold start. Each reset source is applied part-way through a sequence, including a loss of oscillator stability, to confirm that the clear is immediate and that the restart runs from the beginning.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int unsigned RST_SRC_N = 5;
  typedef enum logic [2:0] {
    SRC_POR = 3'd0,
    SRC_BOR = 3'd1,
    SRC_EXT = 3'd2,
    SRC_WDT = 3'd3,
    SRC_OSC = 3'd4
  } rst_src_e;
endpackage

// File: rtl/rws_rst_cell.sv
// Async assert, two-flop synchronous release.
module rws_rst_cell (
  input  logic clk_i,
  input  logic arst_i,
  output logic rel_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rel_o = sync_q[1];

  assert_hold_rst_R1: assert property (@(posedge clk_i) arst_i |=> !rel_o);
endmodule

// File: rtl/rws_timer.sv
module rws_timer #(
  parameter int unsigned TC = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = (TC < 2) ? 1 : $clog2(TC + 1);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == W'(TC));

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)                 cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + W'(1);
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= W'(TC));
  assert_done_sticky_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && !clr_i |=> done_o);
endmodule

// File: rtl/rws_pd_ctrl.sv
module rws_pd_ctrl #(
  parameter int unsigned NUM_WAKE = 12
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                pd_req_i,
  input  logic                granted_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  output logic                pd_o
);
  logic any_wake;
  assign any_wake = |wake_i;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)      pd_o <= 1'b0;
    else if (pd_o)  pd_o <= !any_wake;
    else            pd_o <= pd_req_i && granted_i;
  end

  assert_pd_early_ignored_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !pd_o && !granted_i |=> !pd_o);
  assert_pd_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    pd_o && !any_wake |=> pd_o);
endmodule

// File: rtl/rws_top.sv
module rws_top
  import rws_pkg::*;
#(
  parameter int unsigned CPU_TC   = 3,
  parameter int unsigned MEM_TC   = 511,
  parameter int unsigned INIT_LEN = 250,
  parameter int unsigned NUM_WAKE = 12,
  parameter int unsigned ADDR_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bor_rst_i,
  input  logic                ext_rst_i,
  input  logic                wdt_rst_i,
  input  logic                osc_stable_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic                pd_req_i,
  input  logic                mem_req_i,
  output logic                sys_rst_o,
  output logic                cpu_run_o,
  output logic                mem_init_o,
  output logic                mem_grant_o,
  output logic                mem_wait_o,
  output logic [ADDR_W-1:0]   fetch_addr_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [RST_SRC_N-1:0] src_req;
  logic [RST_SRC_N-1:0] src_rel;

  always_comb begin
    src_req          = '0;
    src_req[SRC_POR] = !rst_ni;
    src_req[SRC_BOR] = bor_rst_i;
    src_req[SRC_EXT] = ext_rst_i;
    src_req[SRC_WDT] = wdt_rst_i;
    src_req[SRC_OSC] = !osc_stable_i;
  end

  for (genvar g = 0; g < RST_SRC_N; g++) begin : g_sync
    rws_rst_cell u_cell (
      .clk_i  (clk_i),
      .arst_i (src_req[g]),
      .rel_o  (src_rel[g])
    );
  end

  assign sys_rst_o = !(&src_rel);

  logic pd_q;
  logic mem_done;
  logic init_done;

  rws_pd_ctrl #(.NUM_WAKE(NUM_WAKE)) u_pd (
    .clk_i     (clk_i),
    .rst_i     (sys_rst_o),
    .pd_req_i  (pd_req_i),
    .granted_i (init_done),
    .wake_i    (wake_req_i),
    .pd_o      (pd_q)
  );

  rws_timer #(.TC(CPU_TC)) u_cpu_tmr (
    .clk_i  (clk_i),
    .rst_i  (sys_rst_o),
    .clr_i  (pd_q),
    .en_i   (1'b1),
    .done_o (cpu_run_o)
  );

  rws_timer #(.TC(MEM_TC)) u_mem_tmr (
    .clk_i  (clk_i),
    .rst_i  (sys_rst_o),
    .clr_i  (pd_q),
    .en_i   (1'b1),
    .done_o (mem_done)
  );

  rws_timer #(.TC(INIT_LEN)) u_init_tmr (
    .clk_i  (clk_i),
    .rst_i  (sys_rst_o),
    .clr_i  (pd_q),
    .en_i   (mem_done),
    .done_o (init_done)
  );

  assign mem_init_o  = mem_done && !init_done;
  assign mem_grant_o = init_done;
  assign mem_wait_o  = mem_req_i && !init_done;

  logic accept;
  assign accept = mem_req_i && cpu_run_o && init_done;

  always_ff @(posedge clk_i or posedge sys_rst_o) begin
    if (sys_rst_o)   fetch_addr_o <= '0;
    else if (accept) fetch_addr_o <= fetch_addr_o + WORD_STEP;
  end

  assert_grant_after_init_R5: assert property (@(posedge clk_i) disable iff (sys_rst_o)
    $rose(mem_grant_o) |-> $past(mem_init_o));
  assert_fetch_step_R7: assert property (@(posedge clk_i) disable iff (sys_rst_o)
    accept |=> fetch_addr_o == $past(fetch_addr_o) + WORD_STEP);
  assert_fetch_hold_R7: assert property (@(posedge clk_i) disable iff (sys_rst_o)
    !accept |=> $stable(fetch_addr_o));

  if (CPU_TC < MEM_TC) begin : g_order
    assert_cpu_before_mem_R4: assert property (@(posedge clk_i) disable iff (sys_rst_o)
      mem_init_o |-> cpu_run_o);
  end
endmodule

// File: tb/rws_top_tb_top.sv
module rws_top_tb_top;
  localparam int CLK_P   = 10;
  localparam int CPU_TC  = 3;
  localparam int MEM_TC  = 40;
  localparam int INIT_LN = 25;
  localparam int NWAKE   = 12;

  logic clk_i = 1'b0;
  logic rst_ni, bor_rst_i, ext_rst_i, wdt_rst_i, osc_stable_i;
  logic [NWAKE-1:0] wake_req_i;
  logic pd_req_i, mem_req_i;
  logic sys_rst_o, cpu_run_o, mem_init_o, mem_grant_o, mem_wait_o;
  logic [31:0] fetch_addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = !clk_i;

  rws_top #(
    .CPU_TC(CPU_TC), .MEM_TC(MEM_TC), .INIT_LEN(INIT_LN),
    .NUM_WAKE(NWAKE), .ADDR_W(32)
  ) dut_i (
    .clk_i, .rst_ni, .bor_rst_i, .ext_rst_i, .wdt_rst_i, .osc_stable_i,
    .wake_req_i, .pd_req_i, .mem_req_i,
    .sys_rst_o, .cpu_run_o, .mem_init_o, .mem_grant_o, .mem_wait_o,
    .fetch_addr_o
  );

  typedef struct packed {
    int   cyc;
    logic pd;
    logic rst;
    logic run;
    logic init;
    logic grant;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{41, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{42, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{66, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{67, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic chk_state(input string req, input logic r, input logic run,
                           input logic init, input logic grant);
    chk({req, " sys_rst"}, 32'(sys_rst_o), 32'(r));
    chk({req, " cpu_run"}, 32'(cpu_run_o), 32'(run));
    chk({req, " mem_init"}, 32'(mem_init_o), 32'(init));
    chk({req, " grant"}, 32'(mem_grant_o), 32'(grant));
  endtask

  // mid-sequence reset from one source, then restart
  task automatic mid_reset(input int which);
    tick(10);
    chk("R10 running before reset", 32'(cpu_run_o), 32'd1);
    case (which)
      0: bor_rst_i = 1'b1;
      1: ext_rst_i = 1'b1;
      2: wdt_rst_i = 1'b1;
      default: osc_stable_i = 1'b0;
    endcase
    #1;
    chk_state("R1 immediate clear", 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 fetch cleared", fetch_addr_o, 32'd0);
    tick(3);
    chk("R2 held while source active", 32'(sys_rst_o), 32'd1);
    bor_rst_i = 1'b0; ext_rst_i = 1'b0; wdt_rst_i = 1'b0; osc_stable_i = 1'b1;
    tick(1);
    chk("R2 not yet released", 32'(sys_rst_o), 32'd1);
    tick(1);
    chk("R10 released", 32'(sys_rst_o), 32'd0);
    tick(2);
    chk("R10 run not early", 32'(cpu_run_o), 32'd0);
    tick(1);
    chk("R10 run restarted", 32'(cpu_run_o), 32'd1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    rst_ni = 1'b0; bor_rst_i = 1'b0; ext_rst_i = 1'b0; wdt_rst_i = 1'b0;
    osc_stable_i = 1'b0; wake_req_i = '0; pd_req_i = 1'b0; mem_req_i = 1'b0;
    tick(3);
    chk_state("R1 reset state", 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 fetch reset", fetch_addr_o, 32'd0);
    rst_ni = 1'b1;
    tick(5);
    chk("R2 waits for oscillator", 32'(sys_rst_o), 32'd1);

    // table walk from oscillator-stable release; k counts edges
    osc_stable_i = 1'b1;
    mem_req_i = 1'b1;
    k = 0;
    for (int i = 0; i < 10; i++) begin
      while (k < TBL[i].cyc) begin
        tick(1);
        k++;
        pd_req_i = 1'b0;
      end
      chk_state($sformatf("R3/R4/R5/R8 vec%0d", i),
                TBL[i].rst, TBL[i].run, TBL[i].init, TBL[i].grant);
      chk("R6 wait", 32'(mem_wait_o), 32'(!TBL[i].grant));
      if (!TBL[i].grant) chk("R7 no fetch before grant", fetch_addr_o, 32'd0);
      pd_req_i = TBL[i].pd;
    end

    // R7: accepted accesses advance by one word
    tick(3);
    chk("R7 fetch advance", fetch_addr_o, 32'd12);
    mem_req_i = 1'b0;
    chk("R6 no wait idle", 32'(mem_wait_o), 32'd0);
    tick(2);
    chk("R7 fetch hold", fetch_addr_o, 32'd12);

    // R8: power-down after grant
    pd_req_i = 1'b1;
    tick(1);
    pd_req_i = 1'b0;
    chk("R8 grant held one edge", 32'(mem_grant_o), 32'd1);
    tick(1);
    chk_state("R8 power-down", 1'b0, 1'b0, 1'b0, 1'b0);
    tick(5);
    chk("R9 stays down", 32'(cpu_run_o), 32'd0);
    mem_req_i = 1'b1;
    #1;
    chk("R6 wait in power-down", 32'(mem_wait_o), 32'd1);
    mem_req_i = 1'b0;

    // R9: wake from highest bit
    wake_req_i[NWAKE-1] = 1'b1;
    tick(1);
    wake_req_i = '0;
    tick(2);
    chk("R9 run not early", 32'(cpu_run_o), 32'd0);
    tick(1);
    chk("R9 run after wake", 32'(cpu_run_o), 32'd1);
    wake_req_i[0] = 1'b1;
    tick(1);
    wake_req_i = '0;
    chk("R9 wake ignored when up", 32'(cpu_run_o), 32'd1);
    tick(MEM_TC + INIT_LN - 5);
    chk("R9 grant not early", 32'(mem_grant_o), 32'd0);
    tick(1);
    chk("R9 grant after wake", 32'(mem_grant_o), 32'd1);
    chk("R7 fetch kept over power-down", fetch_addr_o, 32'd12);

    // R9: wake from lowest bit
    pd_req_i = 1'b1;
    tick(1);
    pd_req_i = 1'b0;
    tick(3);
    chk("R8 down again", 32'(mem_grant_o), 32'd0);
    wake_req_i[0] = 1'b1;
    tick(1);
    wake_req_i = '0;
    tick(3);
    chk("R9 run after bit0 wake", 32'(cpu_run_o), 32'd1);

    // R1/R10: each source mid-sequence
    for (int s = 0; s < 4; s++) mid_reset(s);

    // R10: full restart timing after power-on reset pulse
    tick(4);
    rst_ni = 1'b0;
    #1;
    chk_state("R1 por mid", 1'b1, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    tick(2 + MEM_TC + INIT_LN - 1);
    chk("R10 grant not early", 32'(mem_grant_o), 32'd0);
    tick(1);
    chk("R10 grant after restart", 32'(mem_grant_o), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule